// File: doc/BRIEF.md
# SDRAM Control and Self-Refresh Sequencer

This block sits in front of an SDRAM controller and turns one software-written control word into pin-level behaviour. A small register bus with a single wait state writes and reads that word. The word selects an initialization command, requests self-refresh, and sets how the SDRAM clock output is gated. A status word reports whether the memory is actually in self-refresh.

During bring-up, software writes a command selection into the word. The block emits that command exactly once, as a one-cycle pulse on the command bus, and holds the clock enable high. When the selection is normal operation, the command bus carries the transaction engine's commands, delayed by one register. Self-refresh entry waits for the engine to go idle, then issues one self-refresh command with clock enable dropped. The acknowledge is set only after the SDRAM side reports completion. On exit, clock enable rises first, then the clock restarts, and only then does the acknowledge clear.

Top module: `sdram_ctl_seq`

## Requirements
- R1: After synchronous reset the control word reads 0x03, the status word reads 0x01, sd_cke is 0, clk_gate_en is 1 and sd_cmd is 0 (no-operation).
- R2: An access held on bus_sel gets bus_ready high in its second cycle and never in two consecutive cycles. A write to address 0 takes effect at that point. Writes to control bits above bit 4 are ignored, and those bits read as 0.
- R3: The control field in bits 4:3 selects the bring-up command: 0 is normal, 1 is mode-register set, 2 is precharge-all, 3 is no-operation. The command bus uses code 1 for mode-register set, code 2 for precharge-all and code 0 for no-operation. Each write with a nonzero field puts its code on sd_cmd for exactly one cycle, the cycle in which bus_ready is high, and sd_cmd stays at 0 after that.
- R4: sd_cke is 1 in every cycle in which the bring-up field is nonzero.
- R5: With the field at 0 and no self-refresh activity, sd_cmd equals eng_cmd delayed by one clock. While the field is nonzero, eng_cmd does not reach sd_cmd.
- R6: Bit 1 of the control word requests self-refresh. Once it is set, sd_cmd is 0 until eng_idle is sampled high. The next cycle then shows code 3 (self-refresh) with sd_cke at 0, and sd_cke stays 0. sr_ack rises one cycle after sr_done is sampled, and not before.
- R7: Clearing bit 1 while in self-refresh raises sd_cke two cycles after the write access starts, while clk_gate_en stays as gated and sr_ack stays 1. One cycle after the next sr_done, clk_gate_en is 1. sr_ack clears one cycle after that.
- R8: When bit 0 (free-running clock) is 1, clk_gate_en is 1. When bit 0 is 0, clk_gate_en is the inverse of eng_idle delayed by one clock in normal mode, and it is 0 while in self-refresh.
- R9: When bit 2 (clock off) is 1, clk_gate_en is 0 regardless of the other bits.
- R10: A read of address 1 returns sr_ack in bit 0 and zeros elsewhere. Reads of addresses 2 and 3 return 0.
- R11: If bit 1 is cleared before eng_idle is seen, no self-refresh command is issued and sr_ack stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request, held until bus_ready |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register address: 0 is control, 1 is status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes in this cycle |
| eng_idle | input | 1 | Transaction engine has nothing pending |
| eng_cmd | input | 3 | Command from the transaction engine |
| sr_done | input | 1 | Pulse: the SDRAM finished entering or leaving self-refresh |
| sd_cmd | output | 3 | Command bus to the SDRAM |
| sd_cke | output | 1 | SDRAM clock enable |
| clk_gate_en | output | 1 | Enable for the SDRAM clock output gate |
| sr_ack | output | 1 | Self-refresh acknowledge status |

## Verification
All results are registered, so each one is due a fixed number of cycles after its cause. A write shows up with bus_ready one edge after the access starts, and its bring-up pulse appears in that same cycle. The self-refresh command follows one edge after eng_idle is sampled, sr_ack follows one edge after sr_done, and the gate follows eng_idle by one edge. Exit shows sd_cke after two edges, then the gate, then the acknowledge clear, one edge apart. Inputs change just after a falling edge, and the bench compares every output against its behavioural model at each falling edge. Directed checks are placed at the cycle counts above.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int CTRL_W = 5;
  localparam int CMD_W  = 3;

  localparam logic [CMD_W-1:0] CMD_NOP  = 3'd0;
  localparam logic [CMD_W-1:0] CMD_MODE = 3'd1;
  localparam logic [CMD_W-1:0] CMD_PALL = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SREF = 3'd3;

  typedef enum logic [2:0] {
    ST_RUN, ST_DRAIN, ST_ENTER, ST_SELF, ST_WAKE, ST_RESUME
  } sr_state_e;

  typedef struct packed {
    logic [1:0] init;
    logic       clk_off;
    logic       sr_req;
    logic       clk_run;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{init: 2'd0, clk_off: 1'b0, sr_req: 1'b1, clk_run: 1'b1};

  function automatic logic [CMD_W-1:0] init_code(input logic [1:0] f);
    case (f)
      2'd1:    return CMD_MODE;
      2'd2:    return CMD_PALL;
      default: return CMD_NOP;
    endcase
  endfunction
endpackage

// File: rtl/sdc_regs.sv
module sdc_regs
  import sdc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              sr_ack,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_n,
  output logic              wr_fire
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1);

  logic              access;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_hi;

  assign unused_hi = ^bus_wdata[DATA_W-1:CTRL_W];
  assign access    = bus_sel && !bus_ready;
  assign wr_fire   = access && bus_wr && (bus_addr == CTRL_ADDR);

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_fire) ctrl_n = ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == CTRL_ADDR)      rd_mux[CTRL_W-1:0] = ctrl_q;
    else if (bus_addr == STAT_ADDR) rd_mux[0]          = sr_ack;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      ctrl_q    <= CTRL_RESET;
      bus_rdata <= '0;
    end else begin
      bus_ready <= access;
      ctrl_q    <= ctrl_n;
      if (access && !bus_wr) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/sdc_sr_fsm.sv
module sdc_sr_fsm
  import sdc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sr_req,
  input  logic      eng_idle,
  input  logic      sr_done,
  input  logic      hold,
  output sr_state_e state_q,
  output sr_state_e state_n,
  output logic      sr_ack
);
  always_comb begin
    state_n = state_q;
    case (state_q)
      ST_RUN:    if (sr_req) state_n = ST_DRAIN;
      ST_DRAIN:  if (!sr_req) state_n = ST_RUN;
                 else if (eng_idle && !hold) state_n = ST_ENTER;
      ST_ENTER:  if (sr_done) state_n = ST_SELF;
      ST_SELF:   if (!sr_req) state_n = ST_WAKE;
      ST_WAKE:   if (sr_done) state_n = ST_RESUME;
      ST_RESUME: state_n = ST_RUN;
      default:   state_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SELF;
      sr_ack  <= 1'b1;
    end else begin
      state_q <= state_n;
      if (state_q == ST_ENTER && sr_done) sr_ack <= 1'b1;
      else if (state_q == ST_RESUME)      sr_ack <= 1'b0;
    end
  end
endmodule

// File: rtl/sdc_drive.sv
module sdc_drive
  import sdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl_n,
  input  sr_state_e        state_q,
  input  sr_state_e        state_n,
  input  logic             wr_fire,
  input  logic             eng_idle,
  input  logic [CMD_W-1:0] eng_cmd,
  output logic [CMD_W-1:0] sd_cmd,
  output logic             sd_cke,
  output logic             clk_gate_en
);
  logic [CMD_W-1:0] cmd_d;
  logic             cke_d;
  logic             gate_d;
  logic             in_init;

  assign in_init = (ctrl_n.init != 2'd0);

  always_comb begin
    cmd_d = CMD_NOP;
    if (wr_fire && in_init)
      cmd_d = init_code(ctrl_n.init);
    else if (state_q == ST_DRAIN && state_n == ST_ENTER)
      cmd_d = CMD_SREF;
    else if (state_q == ST_RUN && state_n == ST_RUN && !in_init)
      cmd_d = eng_cmd;
  end

  always_comb begin
    cke_d = in_init || !(state_n == ST_ENTER || state_n == ST_SELF);
    if (ctrl_n.clk_off)      gate_d = 1'b0;
    else if (ctrl_n.clk_run) gate_d = 1'b1;
    else if (in_init)        gate_d = 1'b1;
    else begin
      case (state_n)
        ST_RUN:           gate_d = !eng_idle;
        ST_SELF, ST_WAKE: gate_d = 1'b0;
        default:          gate_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sd_cmd      <= CMD_NOP;
      sd_cke      <= 1'b0;
      clk_gate_en <= 1'b1;
    end else begin
      sd_cmd      <= cmd_d;
      sd_cke      <= cke_d;
      clk_gate_en <= gate_d;
    end
  end
endmodule

// File: rtl/sdram_ctl_seq.sv
module sdram_ctl_seq
  import sdc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic              eng_idle,
  input  logic [CMD_W-1:0]  eng_cmd,
  input  logic              sr_done,
  output logic [CMD_W-1:0]  sd_cmd,
  output logic              sd_cke,
  output logic              clk_gate_en,
  output logic              sr_ack
);
  ctrl_t     ctrl_q;
  ctrl_t     ctrl_n;
  logic      wr_fire;
  sr_state_e state_q;
  sr_state_e state_n;

  sdc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sr_ack(sr_ack),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .ctrl_q(ctrl_q), .ctrl_n(ctrl_n), .wr_fire(wr_fire)
  );

  sdc_sr_fsm u_fsm (
    .clk(clk), .rst(rst), .sr_req(ctrl_q.sr_req), .eng_idle(eng_idle),
    .sr_done(sr_done), .hold(wr_fire),
    .state_q(state_q), .state_n(state_n), .sr_ack(sr_ack)
  );

  sdc_drive u_drive (
    .clk(clk), .rst(rst), .ctrl_n(ctrl_n), .state_q(state_q),
    .state_n(state_n), .wr_fire(wr_fire), .eng_idle(eng_idle),
    .eng_cmd(eng_cmd), .sd_cmd(sd_cmd), .sd_cke(sd_cke),
    .clk_gate_en(clk_gate_en)
  );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
  import sdc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_ready,
  input logic             sr_done,
  input logic [CMD_W-1:0] sd_cmd,
  input logic             sd_cke,
  input logic             clk_gate_en,
  input logic             sr_ack,
  input ctrl_t            ctrl
);
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready);  // R2
  AST_READY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ready) |-> $past(bus_sel));  // R2
  AST_PULSE_ONCE: assert property (@(posedge clk) disable iff (rst)
    (sd_cmd != CMD_NOP && ctrl.init != 2'd0) |=> sd_cmd == CMD_NOP);  // R3
  AST_INIT_CKE: assert property (@(posedge clk) disable iff (rst)
    ctrl.init != 2'd0 |-> sd_cke);  // R4
  AST_CKE_DROP_SREF: assert property (@(posedge clk) disable iff (rst)
    ($fell(sd_cke) && ctrl.init == 2'd0) |-> sd_cmd == CMD_SREF);  // R6
  AST_ACK_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(sr_ack) |-> $past(sr_done) && !sd_cke);  // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_ack) |-> sd_cke && ($past(clk_gate_en) || $past(ctrl.clk_off)));  // R7
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    (ctrl.clk_run && !ctrl.clk_off) |-> clk_gate_en);  // R8
  AST_CLK_OFF: assert property (@(posedge clk) disable iff (rst)
    ctrl.clk_off |-> !clk_gate_en);  // R9
endmodule

bind sdram_ctl_seq sdc_checker u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_ready(bus_ready),
  .sr_done(sr_done), .sd_cmd(sd_cmd), .sd_cke(sd_cke),
  .clk_gate_en(clk_gate_en), .sr_ack(sr_ack), .ctrl(ctrl_q)
);

// File: tb/sdram_ctl_seq_bench.sv
`timescale 1ns/1ps
module sdram_ctl_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        eng_idle = 1'b1;
  logic [2:0]  eng_cmd = 3'd0;
  logic        sr_done = 1'b0;
  logic [2:0]  sd_cmd;
  logic        sd_cke, clk_gate_en, sr_ack;

  int n_checks = 0, n_fail = 0, sref_seen = 0;
  bit started = 1'b0;

  always #4 clk = ~clk;

  sdram_ctl_seq u_sdram_ctl_seq (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .eng_idle(eng_idle), .eng_cmd(eng_cmd),
    .sr_done(sr_done), .sd_cmd(sd_cmd), .sd_cke(sd_cke),
    .clk_gate_en(clk_gate_en), .sr_ack(sr_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model; phase: 0 normal, 1 waiting idle, 2 entering,
  // 3 in self-refresh, 4 leaving, 5 clock back
  int  m_phase;
  bit  m_run, m_req, m_off, m_ack, m_cke, m_gate, m_rdy;
  int  m_field;
  int  m_cmd;
  always @(posedge clk) begin
    int  nxt;
    bit  wfire, afire;
    if (rst) begin
      m_phase = 3; m_run = 1; m_req = 1; m_off = 0; m_field = 0;
      m_ack = 1; m_cke = 0; m_gate = 1; m_cmd = 0; m_rdy = 0;
    end else begin
      afire = bus_sel && !m_rdy;
      wfire = afire && bus_wr && bus_addr == 2'd0;
      nxt = m_phase;
      if (m_phase == 0 && m_req) nxt = 1;
      if (m_phase == 1) begin
        if (!m_req) nxt = 0;
        else if (eng_idle && !wfire) nxt = 2;
      end
      if (m_phase == 2 && sr_done) nxt = 3;
      if (m_phase == 3 && !m_req) nxt = 4;
      if (m_phase == 4 && sr_done) nxt = 5;
      if (m_phase == 5) nxt = 0;
      if (m_phase == 2 && sr_done) m_ack = 1;
      if (m_phase == 5) m_ack = 0;
      if (wfire) begin
        m_run = bus_wdata[0]; m_req = bus_wdata[1];
        m_off = bus_wdata[2]; m_field = int'(bus_wdata[4:3]);
      end
      if (wfire && m_field != 0) m_cmd = (m_field == 3) ? 0 : m_field;
      else if (m_phase == 1 && nxt == 2) m_cmd = 3;
      else if (m_phase == 0 && nxt == 0 && m_field == 0) m_cmd = int'(eng_cmd);
      else m_cmd = 0;
      m_cke = (m_field != 0) || !(nxt == 2 || nxt == 3);
      if (m_off) m_gate = 0;
      else if (m_run || m_field != 0) m_gate = 1;
      else if (nxt == 0) m_gate = !eng_idle;
      else m_gate = !(nxt == 3 || nxt == 4);
      m_rdy = afire;
      m_phase = nxt;
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R3 cmd", 32'(sd_cmd), 32'(m_cmd));
      chk("R4 cke", 32'(sd_cke), 32'(m_cke));
      chk("R8 gate", 32'(clk_gate_en), 32'(m_gate));
      chk("R6 ack", 32'(sr_ack), 32'(m_ack));
      chk("R2 ready", 32'(bus_ready), 32'(m_rdy));
      if (sd_cmd == 3'd3) sref_seen++;
    end
  end

  task automatic xfer(input bit wr, input logic [1:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic [2:0] cmd_rdy);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    do @(negedge clk); while (!bus_ready);
    rd = bus_rdata; cmd_rdy = sd_cmd;
    #1 bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); #1 sr_done = 1'b1;
    @(negedge clk); #1 sr_done = 1'b0;
  endtask

  task automatic set_idle(input bit v);
    @(negedge clk); #1 eng_idle = v;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [2:0]  c;
    int          base;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    chk("R1 cke", 32'(sd_cke), 0);
    chk("R1 gate", 32'(clk_gate_en), 1);
    chk("R1 cmd", 32'(sd_cmd), 0);
    xfer(0, 2'd0, 0, rd, c); chk("R1 ctrl", rd, 32'h3);
    xfer(0, 2'd1, 0, rd, c); chk("R1 R10 status", rd, 32'h1);
    xfer(0, 2'd2, 0, rd, c); chk("R10 unmapped", rd, 32'h0);

    // leave self-refresh (free-running clock), reserved bits written as ones
    xfer(1, 2'd0, 32'hFFFF_FFE1, rd, c);
    xfer(0, 2'd0, 0, rd, c); chk("R2 reserved", rd, 32'h1);
    chk("R7 cke before done", 32'(sd_cke), 1);
    chk("R7 ack held", 32'(sr_ack), 1);
    pulse_done();
    wait_n(2);
    xfer(0, 2'd1, 0, rd, c); chk("R7 R10 ack cleared", rd, 32'h0);

    // bring-up commands
    xfer(1, 2'd0, 32'h11, rd, c); chk("R3 pall", 32'(c), 2);
    chk("R4 cke init", 32'(sd_cke), 1);
    eng_cmd = 3'd6; wait_n(3); chk("R5 blocked", 32'(sd_cmd), 0);
    xfer(1, 2'd0, 32'h09, rd, c); chk("R3 mode", 32'(c), 1);
    xfer(1, 2'd0, 32'h19, rd, c); chk("R3 nop", 32'(c), 0);
    xfer(1, 2'd0, 32'h01, rd, c);
    wait_n(2); chk("R5 pass", 32'(sd_cmd), 6);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #1 eng_cmd = 3'(4 + (i % 4));
    end
    @(negedge clk); chk("R5 pass last", 32'(sd_cmd), 7);

    // clock gating
    xfer(1, 2'd0, 32'h00, rd, c);
    set_idle(0); wait_n(1); chk("R8 busy", 32'(clk_gate_en), 1);
    set_idle(1); wait_n(1); chk("R8 idle", 32'(clk_gate_en), 0);
    xfer(1, 2'd0, 32'h05, rd, c);
    set_idle(0); wait_n(2); chk("R9 off", 32'(clk_gate_en), 0);
    xfer(1, 2'd0, 32'h00, rd, c);
    wait_n(2); chk("R8 back", 32'(clk_gate_en), 1);

    // self-refresh entry with gated clock
    eng_cmd = 3'd0;
    base = sref_seen;
    xfer(1, 2'd0, 32'h02, rd, c);
    wait_n(4);
    chk("R6 waits idle", 32'(sref_seen), 32'(base));
    chk("R6 nop while draining", 32'(sd_cmd), 0);
    set_idle(1);
    @(negedge clk);
    chk("R6 sref", 32'(sd_cmd), 3);
    chk("R6 cke low", 32'(sd_cke), 0);
    wait_n(2); chk("R6 ack waits done", 32'(sr_ack), 0);
    pulse_done();
    chk("R6 ack set", 32'(sr_ack), 1);
    xfer(0, 2'd1, 0, rd, c); chk("R10 status set", rd, 32'h1);
    chk("R8 gated in self-refresh", 32'(clk_gate_en), 0);

    // exit ordering
    xfer(1, 2'd0, 32'h00, rd, c);
    wait_n(1);
    chk("R7 cke first", 32'(sd_cke), 1);
    chk("R7 gate still off", 32'(clk_gate_en), 0);
    pulse_done();
    chk("R7 gate on", 32'(clk_gate_en), 1);
    chk("R7 ack still set", 32'(sr_ack), 1);
    @(negedge clk); chk("R7 ack clear", 32'(sr_ack), 0);

    // request withdrawn before idle
    set_idle(0);
    base = sref_seen;
    xfer(1, 2'd0, 32'h02, rd, c);
    wait_n(3);
    xfer(1, 2'd0, 32'h00, rd, c);
    wait_n(4);
    set_idle(1);
    wait_n(3);
    chk("R11 no sref", 32'(sref_seen), 32'(base));
    chk("R11 ack low", 32'(sr_ack), 0);
    chk("R11 cke high", 32'(sd_cke), 1);

    wait_n(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule